// File: doc/BRIEF.md
# Prescaled 16-bit timer with phase resynchronizer

This block is a 16-bit up-counter for a small processor core. It counts either an internal tick that runs once per instruction cycle, or edges on an external input pin, with a choice of which pin edge counts. The chosen source first goes through a power-of-two prescaler. The prescaler output is then sampled at two fixed points of the four-phase instruction cycle, and only a low-to-high change between two samples moves the count. Because of this, the count reacts to the pin a few clocks late, and a prescaler high pulse that fits between two sample points is dropped.

Software sets the source, the edge, the prescale code and an interrupt enable through one control word. It can load either byte of the count at any time. When the count rolls over from its all-ones value to zero, an overflow flag is set. The flag, gated by the enable, is the interrupt request. An acknowledge pulse from the interrupt controller clears the flag.

The block runs on the oscillator clock. The four phase strobes are one-hot inputs that rotate by one position each clock, so one instruction cycle lasts four clocks.

Top module: `tmr_presync_timer`

## Requirements
- R1: After reset the count is 0000h, the overflow flag and the interrupt request are low, and the control word reads back as zero.
- R2: With control bit 0 set to 1 (internal source) and prescale code 0, the count rises by one per instruction cycle, on the clock edge where the Q4 strobe (qstb[3]) is high.
- R3: The prescale code in control bits 5:2 sets the division. Code 0 bypasses the prescaler. Code n from 1 to 8 divides by 2^n. Codes 9 to 15 divide by 256. After a load clears the prescaler, K source edges give floor((K + 2^(n-1)) / 2^n) increments.
- R4: With control bit 0 set to 0, the pin is the source. Control bit 1 set to 1 counts low-to-high pin edges, and set to 0 counts high-to-low pin edges. Edges of the other polarity do not change the count.
- R5: The count changes only on clock edges where qstb[1] (Q2) or qstb[3] (Q4) is high. In bypass, if the pin is high for a single clock and the resynchronized high falls between two sample points, the count does not change. A two-clock pin high is counted.
- R6: A rollover from FFFFh to 0000h caused by an increment sets the overflow flag. The interrupt request equals the flag ANDed with control bit 6.
- R7: An acknowledge pulse clears the overflow flag. If a rollover happens in the same cycle as the acknowledge, the flag stays set.
- R8: A write strobe for the low or high half loads wr_data into that byte at the next clock edge. It takes priority over an increment in the same cycle, and it clears the prescaler count.
- R9: In external bypass mode, a pin edge driven between clock edges shows up in the count at the third or fourth rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| qstb | input | 4 | One-hot phase strobes Q1..Q4, rotating one position per clock |
| pin | input | 1 | External count input, asynchronous |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word: bit 6 irq enable, bits 5:2 prescale code, bit 1 edge select, bit 0 source select |
| cfg_q | output | 7 | Control word readback |
| wr_lo | input | 1 | Load strobe for the count low byte |
| wr_hi | input | 1 | Load strobe for the count high byte |
| wr_data | input | 8 | Byte to load |
| cnt_lo | output | 8 | Count low byte |
| cnt_hi | output | 8 | Count high byte |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |
| ack | input | 1 | Interrupt acknowledge, clears the flag |

## Verification
Two pairs of events can land on the same edge: a byte load against an increment, and a rollover against an acknowledge. The bench drives the phase strobes itself, so it knows exactly which edge is a Q4 edge. With the internal source in bypass, it puts a load of FFFFh on a Q4 edge and checks that the count reads FFFFh afterwards, not 0000h. It then raises the acknowledge on the following Q4 edge, where the rollover happens, and checks that the flag is still set; an acknowledge on a quiet edge must clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W       = 16;
    localparam int TMR_PS_STAGES   = 8;
    localparam int TMR_PS_CODE_W   = 4;
    localparam int TMR_SYNC_STAGES = 2;

    // phase strobe positions inside qstb
    localparam int PH_Q1 = 0;
    localparam int PH_Q2 = 1;
    localparam int PH_Q3 = 2;
    localparam int PH_Q4 = 3;

    // control word, MSB first
    typedef struct packed {
        logic                     irq_en;
        logic [TMR_PS_CODE_W-1:0] ps_code;
        logic                     edge_rise;
        logic                     src_int;
    } tmr_ctl_t;

    localparam int TMR_CTL_W = $bits(tmr_ctl_t);

    // number of prescaler stages a code selects, saturating at the stage count
    function automatic int tmr_ps_log2(input logic [TMR_PS_CODE_W-1:0] code,
                                       input int stages);
        int v;
        v = int'(code);
        if (v > stages) v = stages;
        return v;
    endfunction

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int SYNC_STAGES = tmr_pkg::TMR_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic q1,
    input  logic q3,
    input  logic src_int,
    input  logic edge_rise,
    output logic level
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   tick_lvl;

    // metastability chain for the asynchronous pin
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= pin;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    // instruction-rate square wave: high after Q3, low after Q1
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_lvl <= 1'b0;
        end else if (q3) begin
            tick_lvl <= 1'b1;
        end else if (q1) begin
            tick_lvl <= 1'b0;
        end
    end

    // the counting edge always appears as a rising edge of level
    always_comb begin
        if (src_int) begin
            level = tick_lvl;
        end else begin
            level = sync_q[SYNC_STAGES-1] ^ ~edge_rise;
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int STAGES = tmr_pkg::TMR_PS_STAGES,
    parameter int CODE_W = tmr_pkg::TMR_PS_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    input  logic [CODE_W-1:0] code,
    input  logic              clr,
    output logic              psout
);
    localparam int SEL_W = $clog2(STAGES + 1);

    logic              level_d;
    logic [STAGES-1:0] pcnt;
    logic [STAGES:0]   tap;
    logic [SEL_W-1:0]  sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
            pcnt    <= '0;
        end else begin
            level_d <= level;
            if (clr) begin
                pcnt <= '0;
            end else if (level && !level_d) begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign tap[0] = level;
    for (genvar g = 1; g <= STAGES; g++) begin : g_tap
        assign tap[g] = pcnt[g-1];
    end

    always_comb begin
        sel = SEL_W'(tmr_pkg::tmr_ps_log2(code, STAGES));
        psout = tap[0];
        for (int k = 1; k <= STAGES; k++) begin
            if (sel == SEL_W'(k)) psout = tap[k];
        end
    end

endmodule

// File: rtl/tmr_phase_sampler.sv
module tmr_phase_sampler (
    input  logic clk,
    input  logic rst,
    input  logic q2,
    input  logic q4,
    input  logic psout,
    output logic inc
);
    logic samp_q;
    logic sample_now;

    assign sample_now = q2 | q4;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
        end else if (sample_now) begin
            samp_q <= psout;
        end
    end

    // a low sample followed by a high sample is one count event
    assign inc = sample_now & psout & ~samp_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = tmr_pkg::TMR_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               ack,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q;
    logic             wr_any, wrap;

    always_comb begin
        wr_any = wr_lo | wr_hi;
        wrap   = inc & ~wr_any & (cnt_q == ALL_ONES);
        cnt_d  = cnt_q;
        if (wr_any) begin
            if (wr_lo) cnt_d[HALF_W-1:0]     = wr_data;
            if (wr_hi) cnt_d[CNT_W-1:HALF_W] = wr_data;
        end else if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (ack) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/tmr_presync_timer.sv
module tmr_presync_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = TMR_CNT_W,
    parameter int PS_STAGES   = TMR_PS_STAGES,
    parameter int SYNC_STAGES = TMR_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           qstb,
    input  logic                 pin,
    input  logic                 cfg_we,
    input  logic [TMR_CTL_W-1:0] cfg_wdata,
    output logic [TMR_CTL_W-1:0] cfg_q,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [CNT_W/2-1:0]   wr_data,
    output logic [CNT_W/2-1:0]   cnt_lo,
    output logic [CNT_W/2-1:0]   cnt_hi,
    output logic                 ovf,
    input  logic                 ack,
    output logic                 irq
);
    localparam int HALF_W = CNT_W / 2;

    tmr_ctl_t         ctl;
    logic             level, psout, inc;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (cfg_we) begin
            ctl <= tmr_ctl_t'(cfg_wdata);
        end
    end

    tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst       (rst),
        .pin       (pin),
        .q1        (qstb[PH_Q1]),
        .q3        (qstb[PH_Q3]),
        .src_int   (ctl.src_int),
        .edge_rise (ctl.edge_rise),
        .level     (level)
    );

    tmr_prescaler #(.STAGES(PS_STAGES), .CODE_W(TMR_PS_CODE_W)) u_ps (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .code  (ctl.ps_code),
        .clr   (wr_lo | wr_hi),
        .psout (psout)
    );

    tmr_phase_sampler u_samp (
        .clk   (clk),
        .rst   (rst),
        .q2    (qstb[PH_Q2]),
        .q4    (qstb[PH_Q4]),
        .psout (psout),
        .inc   (inc)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .ack     (ack),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    assign cfg_q  = TMR_CTL_W'(ctl);
    assign cnt_lo = cnt[HALF_W-1:0];
    assign cnt_hi = cnt[CNT_W-1:HALF_W];
    assign irq    = ovf & ctl.irq_en;

endmodule

// File: rtl/tmr_presync_timer_chk.sv
module tmr_presync_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       q2,
    input logic       q4,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic [7:0] wr_data,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic       ovf,
    input logic       ack,
    input logic       ien,
    input logic       irq
);
    logic [15:0] c;
    assign c = {cnt_hi, cnt_lo};

    p_load_lo_r8: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt_lo == $past(wr_data));

    p_load_hi_r8: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> cnt_hi == $past(wr_data));

    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi) |=> (c == $past(c) || c == $past(c) + 16'd1));

    p_sample_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi && !q2 && !q4) |=> $stable(c));

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(c) == 16'hFFFF && c == 16'h0000 && !$past(wr_lo) && !$past(wr_hi)) |-> ovf);

    p_flag_origin_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(c) == 16'hFFFF);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (irq |-> ovf) and ((ovf && ien) |-> irq));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && c != 16'hFFFF) |=> !ovf);

endmodule

bind tmr_presync_timer tmr_presync_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .q2      (qstb[1]),
    .q4      (qstb[3]),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .ovf     (ovf),
    .ack     (ack),
    .ien     (cfg_q[6]),
    .irq     (irq)
);

// File: tb/sim_tmr_presync_timer.sv
module sim_tmr_presync_timer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] qstb = 4'b0001;
    logic       pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    wire  [6:0] cfg_q;
    wire  [7:0] cnt_lo, cnt_hi;
    wire        ovf, irq;

    int bph = 0;
    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_presync_timer u0 (
        .clk(clk), .rst(rst), .qstb(qstb), .pin(pin),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf(ovf), .ack(ack), .irq(irq)
    );

    // phase strobes change just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            bph  = (bph + 1) % 4;
            qstb = 4'b0001 << bph;
        end
    end

    function automatic int cnt_now();
        return int'({cnt_hi, cnt_lo});
    endfunction

    function automatic int exp_incs(input int k, input int code);
        int n;
        n = (code > 8) ? 8 : code;
        if (n == 0) return k;
        return (k + (1 << (n - 1))) >> n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while (bph != p);
    endtask

    task automatic set_cfg(input logic [6:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // high byte on a Q3 edge, low byte on the following Q4 edge
    task automatic load_at_q4(input logic [15:0] v);
        wait_phase(2);
        wr_hi = 1'b1;
        wr_data = v[15:8];
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b1;
        wr_data = v[7:0];
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic load_both(input logic [7:0] b);
        @(negedge clk);
        wr_lo = 1'b1;
        wr_hi = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    task automatic pulses(input int n, input int hw);
        for (int i = 0; i < n; i++) begin
            pin = 1'b1;
            repeat (hw) @(negedge clk);
            pin = 1'b0;
            repeat (hw) @(negedge clk);
        end
    endtask

    task automatic run_int(input int code, input int k, input logic [15:0] start, input string tag);
        set_cfg({1'b0, 4'(code), 1'b0, 1'b1});
        repeat (6) @(negedge clk);
        load_at_q4(start);
        repeat (4 * k + 2) @(negedge clk);
        chk(tag, cnt_now(), (int'(start) + exp_incs(k, code)) & 16'hFFFF);
    endtask

    initial begin
        int v0, n, code, k, ed;
        logic [15:0] st;
        void'($urandom(32'h1234_5678));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", cnt_now(), 0);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 cfg", int'(cfg_q), 0);

        // R2 internal tick lands on the Q4 edge
        set_cfg(7'h01);
        repeat (6) @(negedge clk);
        load_at_q4(16'h1200);
        repeat (3) @(negedge clk);
        chk("R2 hold before Q4", cnt_now(), 16'h1200);
        @(negedge clk);
        chk("R2 step at Q4", cnt_now(), 16'h1201);
        run_int(0, 25, 16'h00F0, "R2 bypass run");

        // R3 directed: saturating codes and half-ratio boundary
        run_int(12, 384, 16'h0100, "R3 code12");
        run_int(9, 127, 16'h0200, "R3 code9 below half");
        run_int(15, 200, 16'h0300, "R3 code15");
        run_int(1, 1, 16'h0400, "R3 code1 single");

        // R3 random internal runs against the model
        for (int it = 0; it < 16; it++) begin
            code = $urandom_range(0, 15);
            k = $urandom_range(1, 40);
            st = 16'($urandom_range(0, 65535));
            run_int(code, k, st, (code == 0) ? "R2 random" : "R3 random");
        end

        // R4 falling edge select
        pin = 1'b0;
        set_cfg(7'h00);
        repeat (8) @(negedge clk);
        v0 = cnt_now();
        pin = 1'b1;
        repeat (10) @(negedge clk);
        chk("R4 falling ignores rise", cnt_now(), v0);
        pin = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 falling counts fall", cnt_now(), (v0 + 1) & 16'hFFFF);

        // R4 rising edge select
        set_cfg(7'h02);
        repeat (8) @(negedge clk);
        v0 = cnt_now();
        pin = 1'b1;
        repeat (10) @(negedge clk);
        chk("R4 rising counts rise", cnt_now(), (v0 + 1) & 16'hFFFF);
        pin = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 rising ignores fall", cnt_now(), (v0 + 1) & 16'hFFFF);

        // R4 random external runs with prescale
        for (int it = 0; it < 6; it++) begin
            code = $urandom_range(0, 3);
            ed = $urandom_range(0, 1);
            n = $urandom_range(1, 10);
            pin = 1'b0;
            set_cfg({1'b0, 4'(code), 1'(ed), 1'b0});
            repeat (8) @(negedge clk);
            load_both(8'h00);
            pulses(n, 12);
            repeat (8) @(negedge clk);
            chk("R4 random ext", cnt_now(), exp_incs(n, code));
        end

        // R9 latency in external bypass, rising
        set_cfg(7'h02);
        repeat (10) @(negedge clk);
        v0 = cnt_now();
        pin = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cnt_now() == v0 && n < 10);
        chk("R9 latency low bound", int'(n >= 3), 1);
        chk("R9 latency high bound", int'(n <= 4), 1);
        pin = 1'b0;
        repeat (10) @(negedge clk);

        // R5 one-clock pulse resynchronized between samples is lost
        v0 = cnt_now();
        wait_phase(0);
        pin = 1'b1;
        @(negedge clk);
        pin = 1'b0;
        repeat (8) @(negedge clk);
        chk("R5 short pulse lost", cnt_now(), v0);
        wait_phase(0);
        pin = 1'b1;
        repeat (2) @(negedge clk);
        pin = 1'b0;
        repeat (8) @(negedge clk);
        chk("R5 two-clock pulse seen", cnt_now(), (v0 + 1) & 16'hFFFF);

        // R8 load beats increment, R6 wrap, R7 acknowledge
        set_cfg(7'h41);
        repeat (6) @(negedge clk);
        wait_phase(2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 flag clear before wrap", int'(ovf), 0);
        wait_phase(3);
        wr_lo = 1'b1;
        wr_hi = 1'b1;
        wr_data = 8'hFF;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
        chk("R8 load wins over increment", cnt_now(), 16'hFFFF);
        chk("R8 load does not set flag", int'(ovf), 0);
        wait_phase(3);
        @(negedge clk);
        chk("R6 wrap to zero", cnt_now(), 0);
        chk("R6 flag set", int'(ovf), 1);
        chk("R6 irq enabled", int'(irq), 1);
        set_cfg(7'h01);
        chk("R6 irq masked", int'(irq), 0);
        chk("R6 flag held", int'(ovf), 1);
        wait_phase(0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 ack clears", int'(ovf), 0);
        wait_phase(3);
        wr_lo = 1'b1;
        wr_hi = 1'b1;
        wr_data = 8'hFF;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
        wait_phase(3);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 wrap beats ack count", cnt_now(), 0);
        chk("R7 wrap beats ack flag", int'(ovf), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule